// File: doc/BRIEF.md
# Banked GPIO Controller with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O controller reached over a simple 16-bit register bus. The pins are grouped into a low bank (pins 0 to 15) and a high bank (pins 16 to 31). Each pin can be an input or an output. Each pin can also raise an interrupt, with its own choice of level or edge detection, polarity, rising and/or falling edge, and latched or pass-through status. The block also holds a 16-bit register of extra output-only bits and a small pull-resistor control for the lowest pins.

Every pin input passes through a two-flop synchronizer and one more history flop before event detection. An event sets the pin's status bit. When status AND enable is non-zero anywhere, the block raises a single summary interrupt. It also reports the index of the lowest-numbered pending pin, which means any pending low-bank pin always wins over the high bank.

Software configures each pin once, then services interrupts in two steps. It reads the pending index, then clears that pin's status bit by writing a 1 to it.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, every register reads zero, so all pins are inputs, pin_oe and pin_out are zero, interrupts are disabled and pulls are off. An unmapped or odd address reads zero.
- R2: Bus offsets 0x00 (low bank) and 0x02 (high bank) hold the direction bits, and a 1 drives pin_oe for that pin. Offsets 0x04 and 0x06 hold the output values driven on pin_out. Pin n of the high bank uses bit n-16.
- R3: Reading 0x04 or 0x06 returns the output value for pins whose direction bit is 1. For the other pins it returns the synchronized input level, which appears 2 clock edges after pin_in changes.
- R4: Status lives at 0x08 and 0x0A. When the hold bit is set, writing 1 to a status bit clears it and writing 0 leaves it unchanged. A new event in the same cycle as the clear wins.
- R5: The type registers are at 0x10 and 0x12. A type bit of 0 selects level detection, where the polarity bit (0x14/0x16) set to 1 means active-high and 0 means active-low.
- R6: A type bit of 1 selects edge detection. The rising-select bit (0x24/0x26) enables rising edges and the falling-select bit (0x20/0x22) enables falling edges; setting both enables both.
- R7: Hold bits are at 0x18 and 0x1A. With hold at 1, a detected event stays set in status until cleared. With hold at 0, status shows, each cycle, whether the condition was present in the previous cycle.
- R8: irq is 1 exactly when some status bit and the matching enable bit (0x0C/0x0E) are both 1.
- R9: irq_pin gives the lowest-numbered pin whose status and enable are both 1, so low-bank pins take priority. irq_pin_valid is 0 when no such pin exists.
- R10: The pull-enable register (0x28) and the pull-direction register (0x2A, 1 means pull-up) cover pins 0 to 14 only. They drive pull_en and pull_up, and bit 15 reads 0.
- R11: Offset 0x1C holds 16 extra output-only bits that drive aux_out.
- R12: A pin change reaches status, irq and irq_pin on the third rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational, zero when not selected) |
| pin_in | input | 32 | Raw pin levels |
| pin_out | output | 32 | Output values |
| pin_oe | output | 32 | Output enables |
| aux_out | output | 16 | Extra output-only bits |
| pull_en | output | 15 | Pull-resistor enable, pins 0 to 14 |
| pull_up | output | 15 | Pull direction, 1 = up |
| irq | output | 1 | Summary interrupt |
| irq_pin | output | 5 | Lowest pending enabled pin |
| irq_pin_valid | output | 1 | irq_pin is meaningful |

## Verification
Register writes take effect on the edge that samples them, so a read or output check one cycle later sees the new value. A synchronized input level is visible to data reads two edges after pin_in moves. Status, irq and irq_pin follow on the third edge. The bench drives every input 1 ns after a falling edge, advances its behavioural model on each rising edge, and compares all outputs, plus the read data of each read access, at the next falling edge, so each result is checked in the cycle it is due. An explicit latency check confirms that irq is still low after two edges and high after three.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int ADDR_W = 6;

  // Byte offsets of the low-bank register of each pair; high bank is +2.
  localparam logic [ADDR_W-1:0] OFS_DIR      = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_DATA     = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT     = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_EN       = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_TYPE     = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_POL      = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_HOLD     = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_AUX      = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_FALL     = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_RISE     = 6'h24;
  localparam logic [ADDR_W-1:0] OFS_PULL_EN  = 6'h28;
  localparam logic [ADDR_W-1:0] OFS_PULL_DIR = 6'h2A;

  typedef enum logic [3:0] {
    F_NONE, F_DIR, F_DATA, F_STAT, F_EN, F_TYPE, F_POL, F_HOLD, F_FALL, F_RISE
  } bank_field_e;

  typedef struct packed {
    bank_field_e fld;
    logic        bank;
  } bank_sel_t;

  // Map a byte offset onto a banked field and a bank number.
  function automatic bank_sel_t decode_bank(input logic [ADDR_W-1:0] a);
    bank_sel_t r;
    r.bank = a[1];
    r.fld  = F_NONE;
    if (!a[0]) begin
      case ({a[ADDR_W-1:2], 2'b00})
        OFS_DIR:  r.fld = F_DIR;
        OFS_DATA: r.fld = F_DATA;
        OFS_STAT: r.fld = F_STAT;
        OFS_EN:   r.fld = F_EN;
        OFS_TYPE: r.fld = F_TYPE;
        OFS_POL:  r.fld = F_POL;
        OFS_HOLD: r.fld = F_HOLD;
        OFS_FALL: r.fld = F_FALL;
        OFS_RISE: r.fld = F_RISE;
        default:  r.fld = F_NONE;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  // STAGES synchronizer flops plus one history flop for edge detection.
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q[0] <= raw;
      for (int k = 1; k < DEPTH; k++) begin
        pipe_q[k] <= pipe_q[k-1];
      end
    end
  end

  assign cur  = pipe_q[STAGES-1];
  assign prev = pipe_q[STAGES];

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] typ,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] rise,
  input  logic [W-1:0] fall,
  input  logic [W-1:0] hold,
  input  logic [W-1:0] clr,
  output logic [W-1:0] ev,
  output logic [W-1:0] stat_q
);

  // Per-pin detection: level compares with polarity, edges use history.
  function automatic logic [W-1:0] pin_events(
    input logic [W-1:0] c, p, t, pl, r, f);
    logic [W-1:0] lvl_hit;
    logic [W-1:0] edge_hit;
    lvl_hit  = ~(c ^ pl);
    edge_hit = (r & c & ~p) | (f & ~c & p);
    return (t & edge_hit) | (~t & lvl_hit);
  endfunction

  // Held bits keep their value unless cleared; a fresh event always sets.
  function automatic logic [W-1:0] next_status(
    input logic [W-1:0] s, e, h, c);
    return e | (h & s & ~c);
  endfunction

  logic [W-1:0] kept;

  assign ev   = pin_events(cur, prev, typ, pol, rise, fall);
  assign kept = stat_q & hold & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= next_status(stat_q, ev, hold, clr);
  end

  a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & hold & ~ev)) |=> ((stat_q & $past(clr & hold & ~ev)) == '0));

  a_r7_held_bits_stick: assert property (@(posedge clk) disable iff (!rst_n)
    (|kept) |=> ((stat_q & $past(kept)) == $past(kept)));

  a_r7_passthrough_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((stat_q ^ $past(ev)) & $past(~hold)) == '0));

endmodule

// File: rtl/gpio_pend_encoder.sv
module gpio_pend_encoder #(
  parameter int W     = 32,
  parameter int IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     pend,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  // Lowest set bit wins: scan downward so the last hit is the smallest.
  function automatic logic [IDX_W-1:0] lowest_set(input logic [W-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  assign any = |pend;
  assign idx = lowest_set(pend);

  a_r9_index_is_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (pend[idx] && ((pend & ~({W{1'b1}} << idx)) == '0)));

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int BANK_W      = 16,
  parameter int PULL_N      = 15,
  parameter int AUX_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int PIN_N      = 2 * BANK_W,
  localparam int IDX_W      = $clog2(PIN_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BANK_W-1:0] bus_wdata,
  output logic [BANK_W-1:0] bus_rdata,
  input  logic [PIN_N-1:0]  pin_in,
  output logic [PIN_N-1:0]  pin_out,
  output logic [PIN_N-1:0]  pin_oe,
  output logic [AUX_W-1:0]  aux_out,
  output logic [PULL_N-1:0] pull_en,
  output logic [PULL_N-1:0] pull_up,
  output logic              irq,
  output logic [IDX_W-1:0]  irq_pin,
  output logic              irq_pin_valid
);

  localparam int NUM_BANKS = 2;

  bank_sel_t dec;
  logic      wr_en;

  logic [NUM_BANKS-1:0][BANK_W-1:0] dir_q, out_q, en_q, typ_q, pol_q;
  logic [NUM_BANKS-1:0][BANK_W-1:0] hold_q, fall_q, rise_q;
  logic [NUM_BANKS-1:0][BANK_W-1:0] stat_q, ev, clr, cur_b, prev_b, lvl_b;
  logic [AUX_W-1:0]  aux_q;
  logic [PULL_N-1:0] pen_q, pup_q;
  logic [PIN_N-1:0]  cur_all, prev_all, pend;
  logic              pend_any;

  assign dec   = decode_bank(bus_addr);
  assign wr_en = bus_sel & bus_wr;

  // Configuration registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      en_q   <= '0;
      typ_q  <= '0;
      pol_q  <= '0;
      hold_q <= '0;
      fall_q <= '0;
      rise_q <= '0;
      aux_q  <= '0;
      pen_q  <= '0;
      pup_q  <= '0;
    end else if (wr_en) begin
      case (dec.fld)
        F_DIR:   dir_q[dec.bank]  <= bus_wdata;
        F_DATA:  out_q[dec.bank]  <= bus_wdata;
        F_EN:    en_q[dec.bank]   <= bus_wdata;
        F_TYPE:  typ_q[dec.bank]  <= bus_wdata;
        F_POL:   pol_q[dec.bank]  <= bus_wdata;
        F_HOLD:  hold_q[dec.bank] <= bus_wdata;
        F_FALL:  fall_q[dec.bank] <= bus_wdata;
        F_RISE:  rise_q[dec.bank] <= bus_wdata;
        default: ;
      endcase
      if (bus_addr == OFS_AUX)      aux_q <= bus_wdata[AUX_W-1:0];
      if (bus_addr == OFS_PULL_EN)  pen_q <= bus_wdata[PULL_N-1:0];
      if (bus_addr == OFS_PULL_DIR) pup_q <= bus_wdata[PULL_N-1:0];
    end
  end

  gpio_in_sync #(.W(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (pin_in),
    .cur  (cur_all),
    .prev (prev_all)
  );

  assign cur_b  = cur_all;
  assign prev_b = prev_all;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign clr[g] = (wr_en && dec.fld == F_STAT && dec.bank == 1'(g))
                    ? bus_wdata : '0;
    assign lvl_b[g] = (dir_q[g] & out_q[g]) | (~dir_q[g] & cur_b[g]);

    gpio_irq_bank #(.W(BANK_W)) u_irq_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .cur   (cur_b[g]),
      .prev  (prev_b[g]),
      .typ   (typ_q[g]),
      .pol   (pol_q[g]),
      .rise  (rise_q[g]),
      .fall  (fall_q[g]),
      .hold  (hold_q[g]),
      .clr   (clr[g]),
      .ev    (ev[g]),
      .stat_q(stat_q[g])
    );
  end

  assign pend = stat_q & en_q;

  gpio_pend_encoder #(.W(PIN_N), .IDX_W(IDX_W)) u_pend (
    .clk  (clk),
    .rst_n(rst_n),
    .pend (pend),
    .any  (pend_any),
    .idx  (irq_pin)
  );

  assign irq           = pend_any;
  assign irq_pin_valid = pend_any;

  // Read multiplexer.
  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (dec.fld)
        F_DIR:   bus_rdata = dir_q[dec.bank];
        F_DATA:  bus_rdata = lvl_b[dec.bank];
        F_STAT:  bus_rdata = stat_q[dec.bank];
        F_EN:    bus_rdata = en_q[dec.bank];
        F_TYPE:  bus_rdata = typ_q[dec.bank];
        F_POL:   bus_rdata = pol_q[dec.bank];
        F_HOLD:  bus_rdata = hold_q[dec.bank];
        F_FALL:  bus_rdata = fall_q[dec.bank];
        F_RISE:  bus_rdata = rise_q[dec.bank];
        default: begin
          if (bus_addr == OFS_AUX)      bus_rdata = BANK_W'(aux_q);
          if (bus_addr == OFS_PULL_EN)  bus_rdata = BANK_W'(pen_q);
          if (bus_addr == OFS_PULL_DIR) bus_rdata = BANK_W'(pup_q);
        end
      endcase
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign aux_out = aux_q;
  assign pull_en = pen_q;
  assign pull_up = pup_q;

  a_r2_dir_drives_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == OFS_DIR) |=> (pin_oe[BANK_W-1:0] == $past(bus_wdata)));

  a_r8_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

  a_r11_aux_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == OFS_AUX) |=> (aux_out == $past(bus_wdata[AUX_W-1:0])));

endmodule

// File: tb/gpio_irq_unit_tb.sv
`timescale 1ns/1ps
module gpio_irq_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic [15:0] aux_out;
  logic [14:0] pull_en, pull_up;
  logic        irq, irq_pin_valid;
  logic [4:0]  irq_pin;

  int checks = 0, errors = 0, cyc = 0;
  bit chk_on = 0, done = 0;
  string cur_tag = "R1";

  always #2.5 clk = ~clk;

  gpio_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .aux_out(aux_out),
    .pull_en(pull_en), .pull_up(pull_up), .irq(irq), .irq_pin(irq_pin),
    .irq_pin_valid(irq_pin_valid)
  );

  // Behavioural reference model.
  logic [31:0] m_dir, m_out, m_stat, m_en, m_typ, m_pol, m_hold, m_fall, m_rise;
  logic [31:0] m_s1, m_s2, m_p, m_ev, m_clr;
  logic [15:0] m_aux;
  logic [14:0] m_pen, m_pup;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_dir, m_out, m_stat, m_en, m_typ, m_pol, m_hold, m_fall, m_rise} = '0;
      {m_s1, m_s2, m_p} = '0;
      m_aux = '0; m_pen = '0; m_pup = '0;
    end else begin
      for (int i = 0; i < 32; i++) begin
        if (m_typ[i])
          m_ev[i] = (m_rise[i] && m_s2[i] && !m_p[i]) || (m_fall[i] && !m_s2[i] && m_p[i]);
        else
          m_ev[i] = m_pol[i] ? m_s2[i] : !m_s2[i];
      end
      m_clr = '0;
      if (bus_sel && bus_wr && bus_addr == 6'h08) m_clr[15:0]  = bus_wdata;
      if (bus_sel && bus_wr && bus_addr == 6'h0A) m_clr[31:16] = bus_wdata;
      for (int i = 0; i < 32; i++)
        m_stat[i] = m_hold[i] ? ((m_stat[i] && !m_clr[i]) || m_ev[i]) : m_ev[i];
      if (bus_sel && bus_wr) begin
        case (bus_addr)
          6'h00: m_dir[15:0]   = bus_wdata;  6'h02: m_dir[31:16]  = bus_wdata;
          6'h04: m_out[15:0]   = bus_wdata;  6'h06: m_out[31:16]  = bus_wdata;
          6'h0C: m_en[15:0]    = bus_wdata;  6'h0E: m_en[31:16]   = bus_wdata;
          6'h10: m_typ[15:0]   = bus_wdata;  6'h12: m_typ[31:16]  = bus_wdata;
          6'h14: m_pol[15:0]   = bus_wdata;  6'h16: m_pol[31:16]  = bus_wdata;
          6'h18: m_hold[15:0]  = bus_wdata;  6'h1A: m_hold[31:16] = bus_wdata;
          6'h20: m_fall[15:0]  = bus_wdata;  6'h22: m_fall[31:16] = bus_wdata;
          6'h24: m_rise[15:0]  = bus_wdata;  6'h26: m_rise[31:16] = bus_wdata;
          6'h1C: m_aux = bus_wdata;
          6'h28: m_pen = bus_wdata[14:0];
          6'h2A: m_pup = bus_wdata[14:0];
          default: ;
        endcase
      end
      m_p = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  function automatic logic [15:0] m_read(input logic [5:0] a);
    logic [31:0] lvl;
    lvl = (m_dir & m_out) | (~m_dir & m_s2);
    case (a)
      6'h00: return m_dir[15:0];   6'h02: return m_dir[31:16];
      6'h04: return lvl[15:0];     6'h06: return lvl[31:16];
      6'h08: return m_stat[15:0];  6'h0A: return m_stat[31:16];
      6'h0C: return m_en[15:0];    6'h0E: return m_en[31:16];
      6'h10: return m_typ[15:0];   6'h12: return m_typ[31:16];
      6'h14: return m_pol[15:0];   6'h16: return m_pol[31:16];
      6'h18: return m_hold[15:0];  6'h1A: return m_hold[31:16];
      6'h20: return m_fall[15:0];  6'h22: return m_fall[31:16];
      6'h24: return m_rise[15:0];  6'h26: return m_rise[31:16];
      6'h1C: return m_aux;
      6'h28: return {1'b0, m_pen};
      6'h2A: return {1'b0, m_pup};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic int m_lowest(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every cycle, away from the rising edge.
  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      chk("R2", pin_oe, m_dir);
      chk("R2", pin_out, m_out);
      chk("R11", {16'h0, aux_out}, {16'h0, m_aux});
      chk("R10", {17'h0, pull_en}, {17'h0, m_pen});
      chk("R10", {17'h0, pull_up}, {17'h0, m_pup});
      chk("R8", {31'h0, irq}, {31'h0, |(m_stat & m_en)});
      chk("R9", {31'h0, irq_pin_valid}, {31'h0, |(m_stat & m_en)});
      if (|(m_stat & m_en)) chk("R9", {27'h0, irq_pin}, 32'(m_lowest(m_stat & m_en)));
      if (bus_sel && !bus_wr) chk(cur_tag, {16'h0, bus_rdata}, {16'h0, m_read(bus_addr)});
    end
  end

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, input string tag);
    @(negedge clk); #1;
    cur_tag = tag; bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic setpins(input logic [31:0] v);
    @(negedge clk); #1;
    pin_in = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3); #1;
    rst_n = 1;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1", pin_oe, 32'h0);
    chk("R1", pin_out, 32'h0);
    chk("R1", {31'h0, irq}, 32'h0);
    chk("R1", {17'h0, pull_en}, 32'h0);
    chk_on = 1;
    rd(6'h00, "R1"); rd(6'h0E, "R1"); rd(6'h18, "R1"); rd(6'h3E, "R1"); rd(6'h05, "R1");

    // R2: direction and output values, both banks
    wr(6'h00, 16'h00FF); wr(6'h02, 16'h8001);
    wr(6'h04, 16'h0F0F); wr(6'h06, 16'hFFFF);
    rd(6'h00, "R2"); rd(6'h02, "R2");

    // R3: data read mixes output latch and synchronized input
    setpins(32'hA5A5_3C3C);
    idle(3);
    rd(6'h04, "R3"); rd(6'h06, "R3");
    wr(6'h00, 16'h0000); wr(6'h02, 16'h0000);
    setpins(32'h0);
    idle(3);

    // R5/R7: level mode, pin 3, pass-through status
    wr(6'h14, 16'h0008); wr(6'h0C, 16'h0008);
    idle(4);
    chk("R5", {31'h0, irq}, 32'h0);
    setpins(32'h0000_0008);
    idle(4);
    chk("R5", {31'h0, irq}, 32'h1);
    rd(6'h08, "R5");
    setpins(32'h0);
    idle(4);
    chk("R7", {31'h0, irq}, 32'h0);
    rd(6'h08, "R7");
    wr(6'h14, 16'h0000);
    idle(3);
    chk("R5", {31'h0, irq}, 32'h1);
    wr(6'h0C, 16'h0000);

    // R6/R12/R4: rising edge on pin 20, held
    wr(6'h12, 16'h0010); wr(6'h26, 16'h0010); wr(6'h1A, 16'h0010);
    idle(2);
    wr(6'h0A, 16'hFFFF); wr(6'h0E, 16'h0010);
    idle(2);
    setpins(32'h0010_0000);
    @(negedge clk);
    @(negedge clk);
    chk("R12", {31'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R12", {31'h0, irq}, 32'h1);
    chk("R6", {27'h0, irq_pin}, 32'd20);
    setpins(32'h0);
    idle(4);
    chk("R7", {31'h0, irq}, 32'h1);
    rd(6'h0A, "R7");
    wr(6'h0A, 16'h0000);
    rd(6'h0A, "R4");
    chk("R4", {31'h0, irq}, 32'h1);
    wr(6'h0A, 16'h0010);
    rd(6'h0A, "R4");
    chk("R4", {31'h0, irq}, 32'h0);

    // R6: falling only, then both edges
    wr(6'h26, 16'h0000); wr(6'h22, 16'h0010);
    setpins(32'h0010_0000);
    idle(4);
    chk("R6", {31'h0, irq}, 32'h0);
    setpins(32'h0);
    idle(4);
    chk("R6", {31'h0, irq}, 32'h1);
    wr(6'h0A, 16'h0010);
    wr(6'h26, 16'h0010);
    setpins(32'h0010_0000);
    idle(4);
    chk("R6", {31'h0, irq}, 32'h1);
    wr(6'h0A, 16'h0010);
    idle(1);
    setpins(32'h0);
    idle(4);
    chk("R6", {31'h0, irq}, 32'h1);
    wr(6'h0A, 16'h0010);
    wr(6'h0E, 16'h0000);

    // R9: priority between pin 5 (low bank) and pin 17 (high bank)
    wr(6'h10, 16'h0020); wr(6'h24, 16'h0020); wr(6'h18, 16'h0020);
    wr(6'h12, 16'h0002); wr(6'h26, 16'h0002); wr(6'h1A, 16'h0002); wr(6'h22, 16'h0000);
    wr(6'h08, 16'hFFFF); wr(6'h0A, 16'hFFFF);
    wr(6'h0C, 16'h0020); wr(6'h0E, 16'h0002);
    setpins(32'h0002_0020);
    idle(4);
    chk("R9", {27'h0, irq_pin}, 32'd5);
    wr(6'h08, 16'h0020);
    idle(1);
    chk("R9", {27'h0, irq_pin}, 32'd17);
    wr(6'h0A, 16'h0002);
    idle(1);
    chk("R9", {31'h0, irq_pin_valid}, 32'h0);

    // R10/R11: pulls and extra output bits
    wr(6'h28, 16'hFFFF); wr(6'h2A, 16'hAAAA);
    rd(6'h28, "R10"); rd(6'h2A, "R10");
    wr(6'h1C, 16'h1234);
    rd(6'h1C, "R11");
    chk("R11", {16'h0, aux_out}, 32'h1234);
    idle(3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule